// File: doc/BRIEF.md
# SDRAM Initialization Sequencer

This block drives the start-up command sequence of an SDRAM attached to a memory controller. It runs once when reset is released. It runs again whenever software writes any of the three low byte lanes of the SDRAM configuration register. While it runs it keeps the controller from granting any memory access. It drives the chip-select, row-strobe, column-strobe and write-enable command pins, the clock enable and the address bus.

After an optional precharge-all, the sequence raises clock enable and idles on NOP commands for eight refresh intervals. The length of one interval is the programmed refresh-rate count. It then precharges all banks and issues eight auto-refresh commands. Next it loads the mode register from the mode input. It ends with a refresh cycle. The programmed precharge and refresh recovery counts set the spacing of the commands. A trigger that arrives during a run restarts the run from its first step.

Top module: `sdram_init_seq`

## Requirements
- R1: A run starts in the first clock cycle after reset is released, or at the clock edge that samples `cfg_wr` high with any of `cfg_be[2:0]` set. A write whose only enabled lane is `cfg_be[3]` starts nothing: `busy` stays low and no command is issued.
- R2: `busy` is high during reset and from the cycle after a trigger until the final refresh. `mem_grant` equals `mem_req` when `busy` is low and is low whenever `busy` is high.
- R3: A run started by a register write while `bank_open` and `cke` are both high first issues a precharge-all, in the cycle after the trigger edge. A run started by reset release, or with `bank_open` low, has no such leading command.
- R4: `cke` is low during reset and issues only NOP. `cke` rises as the power-up wait starts and then stays high. The wait starts in the cycle after the trigger edge, or `max(t_rp,1)` cycles after a leading precharge. The wait-ending precharge-all comes exactly `8*max(rr_count,1)` cycles after the wait starts, with only NOPs in between.
- R5: Command codes are active-low `{cs_n,ras_n,cas_n,we_n}`: NOP=0111, precharge=0010, refresh=0001, load-mode=0000. Every precharge drives `addr[10]` high.
- R6: After the wait-ending precharge come exactly eight refresh commands. The first comes `max(t_rp,1)` cycles after that precharge, and each later one `max(t_rfc,1)` cycles after the previous refresh.
- R7: A load-mode command follows the eighth refresh after `max(t_rfc,1)` cycles. It carries `mode_val` on `addr[9:0]`, with the higher address bits zero. The next command follows it 2 cycles later.
- R8: The closing refresh cycle is a precharge-all only if `bank_open` is high, then `max(t_rp,1)` cycles later one refresh. With `bank_open` low, the single refresh is the command that comes 2 cycles after the load-mode command.
- R9: `init_done` is high for exactly one cycle, the cycle in which the final refresh appears on the pins, and `busy` is low in that cycle.
- R10: A trigger during a run abandons it. The sequence restarts from its first step, and a leading precharge is decided again from the trigger source and `bank_open`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe of the SDRAM configuration register |
| cfg_be | input | 4 | Byte-lane enables of that write |
| rr_count | input | RR_W | Refresh-rate count: cycles in one refresh interval |
| t_rp | input | TW | Precharge recovery, in cycles |
| t_rfc | input | TW | Refresh recovery, in cycles |
| mode_val | input | 10 | Value loaded into the SDRAM mode register |
| bank_open | input | 1 | High while any SDRAM bank is open |
| mem_req | input | 1 | Memory access request from the controller |
| mem_grant | output | 1 | Access granted; never while a run is active |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | SDRAM address bus |
| busy | output | 1 | Initialization run in progress |
| init_done | output | 1 | One-cycle pulse with the final refresh |

## Verification
The main sequence is run under five parameter sets. These mix reset starts and register-write starts, open and closed banks, zero recovery counts that must behave as one, and distinct refresh-rate and mode values. Each run logs every non-NOP command with its cycle and address and compares the log with a sequence built from the requirements. A wrong interval, a wrong spacing, a missing or extra precharge, or a wrong refresh count each shows up as a different mismatch. Directed cases check a write to the top byte lane alone, grant behaviour when idle and when busy, and a restart in the middle of the power-up wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Active-low {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LEAD_GAP,
        ST_PWAIT,
        ST_AREF,
        ST_LMR,
        ST_FPRE,
        ST_FREF,
        ST_IDLE
    } seq_state_e;

    localparam int unsigned AREF_COUNT      = 8;
    localparam int unsigned PWAIT_INTERVALS = 8;
    localparam int unsigned LMR_SPACING     = 2;
    localparam int unsigned MODE_W          = 10;
    localparam int unsigned ALL_BANKS_BIT   = 10;
    localparam logic [3:0]  TRIG_LANE_MASK  = 4'b0111;

    typedef struct packed {
        logic start;
        logic lead_pre;
    } start_req_t;

    typedef struct packed {
        sd_cmd_e cmd;
        logic    all_banks;
        logic    load_mode;
    } cmd_slot_t;

    function automatic logic lane_trigger(input logic wr, input logic [3:0] be);
        return wr & (|(be & TRIG_LANE_MASK));
    endfunction

endpackage

// File: rtl/sdram_init_trigger.sv
module sdram_init_trigger
    import sdram_init_pkg::*;
(
    input  logic       cfg_wr,
    input  logic [3:0] cfg_be,
    input  logic       bank_open,
    input  logic       cke_on,
    output start_req_t req
);
    always_comb begin
        req.start    = lane_trigger(cfg_wr, cfg_be);
        req.lead_pre = req.start & bank_open & cke_on;
    end
endmodule

// File: rtl/sdram_init_gap.sv
module sdram_init_gap #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] span,
    output logic         zero
);
    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= (span == '0) ? '0 : span - W'(1);
        end else if (left != '0) begin
            left <= left - W'(1);
        end
    end

    assign zero = (left == '0);
endmodule

// File: rtl/sdram_init_pwait.sv
module sdram_init_pwait #(
    parameter int unsigned RR_W      = 16,
    parameter int unsigned INTERVALS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [RR_W-1:0] rr_count,
    output logic            expire
);
    localparam int unsigned IV_W = (INTERVALS > 2) ? $clog2(INTERVALS) : 1;

    logic [RR_W-1:0] cyc_left;
    logic [IV_W-1:0] ivl_left;
    logic            running;
    logic [RR_W-1:0] rr_eff;

    assign rr_eff = (rr_count == '0) ? RR_W'(1) : rr_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            cyc_left <= '0;
            ivl_left <= '0;
        end else if (start) begin
            running  <= 1'b1;
            cyc_left <= rr_eff - RR_W'(1);
            ivl_left <= IV_W'(INTERVALS - 1);
        end else if (running) begin
            if (cyc_left == '0) begin
                if (ivl_left == '0) begin
                    running <= 1'b0;
                end else begin
                    ivl_left <= ivl_left - IV_W'(1);
                    cyc_left <= rr_eff - RR_W'(1);
                end
            end else begin
                cyc_left <= cyc_left - RR_W'(1);
            end
        end
    end

    assign expire = running && (cyc_left == '0) && (ivl_left == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  start_req_t        trig,
    input  logic              gap_zero,
    input  logic              pw_expire,
    input  logic              bank_open,
    input  logic [TW-1:0]     t_rp,
    input  logic [TW-1:0]     t_rfc,
    input  logic [MODE_W-1:0] mode_val,
    output logic              pw_start,
    output logic              gap_load,
    output logic [TW-1:0]     gap_span,
    output cmd_slot_t         slot_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              cke_q,
    output logic              done_q,
    output logic              busy
);
    localparam int unsigned AR_W = $clog2(AREF_COUNT + 1);

    seq_state_e state_q, state_n;
    cmd_slot_t  slot_n;
    logic       cke_n, done_n;
    logic [AR_W-1:0] aref_q, aref_n;

    always_comb begin
        state_n  = state_q;
        slot_n   = '{cmd: CMD_NOP, all_banks: 1'b0, load_mode: 1'b0};
        cke_n    = cke_q;
        done_n   = 1'b0;
        aref_n   = aref_q;
        pw_start = 1'b0;
        if (trig.start) begin
            if (trig.lead_pre) begin
                slot_n  = '{cmd: CMD_PRE, all_banks: 1'b1, load_mode: 1'b0};
                state_n = ST_LEAD_GAP;
            end else begin
                state_n  = ST_PWAIT;
                cke_n    = 1'b1;
                pw_start = 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    state_n  = ST_PWAIT;
                    cke_n    = 1'b1;
                    pw_start = 1'b1;
                end
                ST_LEAD_GAP: if (gap_zero) begin
                    state_n  = ST_PWAIT;
                    cke_n    = 1'b1;
                    pw_start = 1'b1;
                end
                ST_PWAIT: if (pw_expire) begin
                    slot_n  = '{cmd: CMD_PRE, all_banks: 1'b1, load_mode: 1'b0};
                    aref_n  = AR_W'(AREF_COUNT);
                    state_n = ST_AREF;
                end
                ST_AREF: if (gap_zero) begin
                    slot_n.cmd = CMD_REF;
                    aref_n     = aref_q - AR_W'(1);
                    if (aref_q == AR_W'(1)) state_n = ST_LMR;
                end
                ST_LMR: if (gap_zero) begin
                    slot_n  = '{cmd: CMD_LMR, all_banks: 1'b0, load_mode: 1'b1};
                    state_n = ST_FPRE;
                end
                ST_FPRE: if (gap_zero) begin
                    if (bank_open) begin
                        slot_n  = '{cmd: CMD_PRE, all_banks: 1'b1, load_mode: 1'b0};
                        state_n = ST_FREF;
                    end else begin
                        slot_n.cmd = CMD_REF;
                        done_n     = 1'b1;
                        state_n    = ST_IDLE;
                    end
                end
                ST_FREF: if (gap_zero) begin
                    slot_n.cmd = CMD_REF;
                    done_n     = 1'b1;
                    state_n    = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        gap_load = (slot_n.cmd != CMD_NOP);
        unique case (slot_n.cmd)
            CMD_REF: gap_span = t_rfc;
            CMD_LMR: gap_span = TW'(LMR_SPACING);
            default: gap_span = t_rp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            slot_q  <= '{cmd: CMD_NOP, all_banks: 1'b0, load_mode: 1'b0};
            mode_q  <= '0;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
            aref_q  <= '0;
        end else begin
            state_q <= state_n;
            slot_q  <= slot_n;
            cke_q   <= cke_n;
            done_q  <= done_n;
            aref_q  <= aref_n;
            if (slot_n.load_mode) mode_q <= mode_val;
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  cmd_slot_t         slot,
    input  logic [MODE_W-1:0] mode_q,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = slot.cmd;
        addr = '0;
        if (slot.load_mode) begin
            addr[MODE_W-1:0] = mode_q;
        end else if (slot.all_banks) begin
            addr[ALL_BANKS_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned RR_W   = 16,
    parameter int unsigned TW     = 8,
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [RR_W-1:0]   rr_count,
    input  logic [TW-1:0]     t_rp,
    input  logic [TW-1:0]     t_rfc,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              bank_open,
    input  logic              mem_req,
    output logic              mem_grant,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              init_done
);
    start_req_t        trig;
    cmd_slot_t         slot_q;
    logic [MODE_W-1:0] mode_q;
    logic              gap_zero, gap_load, pw_start, pw_expire;
    logic [TW-1:0]     gap_span;

    sdram_init_trigger u_trig (
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .bank_open(bank_open),
        .cke_on(cke), .req(trig)
    );

    sdram_init_gap #(.W(TW)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .span(gap_span), .zero(gap_zero)
    );

    sdram_init_pwait #(.RR_W(RR_W), .INTERVALS(PWAIT_INTERVALS)) u_pwait (
        .clk(clk), .rst(rst), .start(pw_start), .rr_count(rr_count), .expire(pw_expire)
    );

    sdram_init_fsm #(.TW(TW)) u_fsm (
        .clk(clk), .rst(rst), .trig(trig), .gap_zero(gap_zero),
        .pw_expire(pw_expire), .bank_open(bank_open), .t_rp(t_rp),
        .t_rfc(t_rfc), .mode_val(mode_val), .pw_start(pw_start),
        .gap_load(gap_load), .gap_span(gap_span), .slot_q(slot_q),
        .mode_q(mode_q), .cke_q(cke), .done_q(init_done), .busy(busy)
    );

    sdram_init_pins #(.ADDR_W(ADDR_W)) u_pins (
        .slot(slot_q), .mode_q(mode_q), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr)
    );

    assign mem_grant = mem_req & ~busy;
endmodule

// File: rtl/sdram_init_sva.sv
module sdram_init_sva #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [3:0]        cfg_be,
    input logic [9:0]        mode_val,
    input logic              mem_grant,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              init_done
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_wr && (cfg_be[2:0] != 3'b000))); // R1
    AST_TOP_LANE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_wr && cfg_be[2:0] == 3'b000) |=> !busy); // R1
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_grant); // R2
    AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (rst)
        !cke |-> pins == 4'b0111); // R4
    AST_CKE_STAYS: assert property (@(posedge clk) disable iff (rst)
        $past(cke) |-> cke); // R4
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0010 |-> addr[10]); // R5
    AST_LMR_MODE: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0000 |-> addr[9:0] == $past(mode_val)); // R7
    AST_DONE_WITH_REF: assert property (@(posedge clk) disable iff (rst)
        init_done |-> pins == 4'b0001 && !busy); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        init_done |=> !init_done); // R9
endmodule

bind sdram_init_seq sdram_init_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .mode_val(mode_val),
    .mem_grant(mem_grant), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .busy(busy), .init_done(init_done)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
    localparam int RR_W = 16, TW = 8, ADDR_W = 13;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

    typedef struct packed {
        logic [15:0] rr;
        logic [7:0]  rp;
        logic [7:0]  rfc;
        logic [9:0]  mode;
        logic        bank;
        logic        by_write;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{16'd10, 8'd2, 8'd6, 10'h233, 1'b0, 1'b0},
        '{16'd6,  8'd3, 8'd4, 10'h15A, 1'b1, 1'b1},
        '{16'd4,  8'd1, 8'd1, 10'h3FF, 1'b0, 1'b1},
        '{16'd7,  8'd0, 8'd0, 10'h001, 1'b1, 1'b1},
        '{16'd5,  8'd4, 8'd7, 10'h200, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1, cfg_wr = 1'b0, bank_open = 1'b0, mem_req = 1'b1;
    logic [3:0] cfg_be = '0;
    logic [RR_W-1:0] rr_count = 16'd10;
    logic [TW-1:0] t_rp = '0, t_rfc = '0;
    logic [9:0] mode_val = '0;
    logic mem_grant, cke, cs_n, ras_n, cas_n, we_n, busy, init_done;
    logic [ADDR_W-1:0] addr;

    sdram_init_seq #(.RR_W(RR_W), .TW(TW), .ADDR_W(ADDR_W)) u_sdram_init_seq (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .rr_count(rr_count),
        .t_rp(t_rp), .t_rfc(t_rfc), .mode_val(mode_val), .bank_open(bank_open),
        .mem_req(mem_req), .mem_grant(mem_grant), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .busy(busy),
        .init_done(init_done)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0, n_err = 0;
    logic [3:0] log_cmd [32];
    int log_cyc [32];
    logic [ADDR_W-1:0] log_addr [32];
    int n_log = 0, done_cnt = 0, done_cyc = -1, t0 = 0;
    logic busy_at_done = 1'b1;

    logic [3:0] exp_cmd [16];
    int exp_cyc [16];
    int n_exp;

    // monitor samples 3 time units after each rising edge
    initial forever begin
        @(posedge clk);
        #3;
        if ({cs_n, ras_n, cas_n, we_n} != NOP && !rst && n_log < 32) begin
            log_cmd[n_log] = {cs_n, ras_n, cas_n, we_n};
            log_cyc[n_log] = cyc;
            log_addr[n_log] = addr;
            n_log++;
        end
        if (init_done === 1'b1) begin
            done_cnt++;
            done_cyc = cyc;
            busy_at_done = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic apply(input vec_t v);
        @(negedge clk);
        rr_count = v.rr; t_rp = v.rp; t_rfc = v.rfc; mode_val = v.mode; bank_open = v.bank;
    endtask

    task automatic write_trigger(input logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = be; n_log = 0; done_cnt = 0;
        @(posedge clk);
        #1 t0 = cyc;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic reset_start();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; n_log = 0; done_cnt = 0;
        @(posedge clk);
        #1 t0 = cyc;
        #2 chk(cke === 1'b1, "R4", "cke after reset release", cke, 1);
    endtask

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic build_expect(input vec_t v, input bit lead);
        int c = t0;
        n_exp = 0;
        if (lead) begin
            exp_cmd[n_exp] = PRE; exp_cyc[n_exp] = c; n_exp++;
            c += eff(v.rp);
        end
        c += 8 * eff(v.rr);
        exp_cmd[n_exp] = PRE; exp_cyc[n_exp] = c; n_exp++;
        for (int k = 0; k < 8; k++) begin
            c += (k == 0) ? eff(v.rp) : eff(v.rfc);
            exp_cmd[n_exp] = REF; exp_cyc[n_exp] = c; n_exp++;
        end
        c += eff(v.rfc);
        exp_cmd[n_exp] = LMR; exp_cyc[n_exp] = c; n_exp++;
        c += 2;
        if (v.bank) begin
            exp_cmd[n_exp] = PRE; exp_cyc[n_exp] = c; n_exp++;
            c += eff(v.rp);
        end
        exp_cmd[n_exp] = REF; exp_cyc[n_exp] = c; n_exp++;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_cnt == 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (guard == 2)
                chk(busy === 1'b1 && mem_grant === 1'b0, "R2", "grant blocked while busy",
                    mem_grant, 0);
        end
        @(negedge clk);
    endtask

    task automatic compare(input vec_t v, input bit lead);
        build_expect(v, lead);
        chk(n_log == n_exp, "R6", "number of commands", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            string tag;
            if (i == 0 && lead) tag = "R3";
            else if (i == (lead ? 1 : 0)) tag = "R4";
            else if (exp_cmd[i] == LMR) tag = "R7";
            else if (i >= n_exp - 2 && exp_cmd[i] != REF) tag = "R8";
            else if (i == n_exp - 1) tag = "R8";
            else tag = "R6";
            chk(log_cmd[i] == exp_cmd[i], tag, $sformatf("command %0d code", i),
                log_cmd[i], exp_cmd[i]);
            chk(log_cyc[i] == exp_cyc[i], tag, $sformatf("command %0d cycle", i),
                log_cyc[i] - t0, exp_cyc[i] - t0);
            if (exp_cmd[i] == PRE)
                chk(log_addr[i][10] == 1'b1, "R5", "precharge addr10", log_addr[i][10], 1);
            if (exp_cmd[i] == LMR)
                chk(log_addr[i] == {3'b000, v.mode}, "R7", "load-mode address",
                    log_addr[i], {3'b000, v.mode});
        end
        chk(done_cnt == 1, "R9", "init_done pulse count", done_cnt, 1);
        chk(done_cyc == exp_cyc[n_exp-1], "R9", "init_done cycle", done_cyc - t0,
            exp_cyc[n_exp-1] - t0);
        chk(busy_at_done == 1'b0, "R9", "busy at done", busy_at_done, 0);
        chk(busy === 1'b0 && mem_grant === 1'b1, "R2", "grant when idle", mem_grant, 1);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk(cke === 1'b0, "R4", "cke in reset", cke, 0);
        chk(busy === 1'b1, "R2", "busy in reset", busy, 1);
        chk(mem_grant === 1'b0, "R2", "grant in reset", mem_grant, 0);
        chk({cs_n, ras_n, cas_n, we_n} === NOP, "R5", "NOP in reset",
            {cs_n, ras_n, cas_n, we_n}, NOP);

        // vector table, one loop
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            if (VECS[i].by_write) write_trigger(4'b0001 << (i % 3));
            else reset_start();
            wait_done();
            compare(VECS[i], VECS[i].by_write && VECS[i].bank);
        end

        // R1: write touching only the top lane starts nothing
        apply(VECS[1]);
        write_trigger(4'b1000);
        repeat (10) @(negedge clk);
        chk(busy === 1'b0, "R1", "busy after top-lane write", busy, 0);
        chk(n_log == 0, "R1", "commands after top-lane write", n_log, 0);
        chk(mem_grant === 1'b1, "R1", "grant after top-lane write", mem_grant, 1);

        // R10: restart in mid-wait, with bank open so a leading precharge appears
        apply(VECS[1]);
        bank_open = 1'b0;
        write_trigger(4'b0100);
        repeat (15) @(negedge clk);
        bank_open = 1'b1;
        write_trigger(4'b0010);
        wait_done();
        chk(n_log > 0 && log_cmd[0] == PRE && log_cyc[0] == t0, "R10",
            "restart leading precharge cycle", log_cyc[0] - t0, 0);
        compare(VECS[1], 1'b1);

        summary();
        $finish;
    end
endmodule